// File: doc/BRIEF.md
# Multi-Link Splitter Routing Switch

This block is one switching node at a fixed stage of a multistage splitter network. It has twice as many incoming links as a direction has outgoing links: `2*MULT` inputs feed `MULT` upper and `MULT` lower outputs. The links inside a direction are interchangeable. Each packet carries a destination address in its top bits. The node reads the address bit that belongs to its stage and sends the packet upward when that bit is 0 and downward when it is 1. Any free link in that direction may take the packet.

Each packet moves as a single beat. Every port uses valid/ready. An input completes a transfer on a rising edge where both its valid and its ready are high. An input must hold its valid high and its packet stable until that happens. Ready is computed combinationally from the input's own valid, the routing bit and the state of the outputs. Ready is therefore never high for an idle input.

Each outgoing link has one output register. A link is free when that register is empty, or when it is full and the downstream side asserts ready in the same cycle. An output holds its packet until the downstream side accepts it. The stage index, the address width, the payload width and `MULT` are all parameters. When `MULT` is 1 there is one link per direction, and the route through the network is fixed.

Top module: `splitter_switch`

## Requirements
- R1: Routing bit k of the address is packet bit `DATA_W+ADDR_W-1-k`, so bit 0 is the most significant address bit. The switch at stage `LEVEL` reads routing bit `LEVEL`. A value of 0 sends the packet to an up link and a value of 1 sends it to a down link.
- R2: A link is free when its output valid is low, or when its output valid and ready are both high. Only free links receive packets.
- R3: Inside one direction, requesting inputs are served in order of input index, lowest first. The n-th requesting input gets the n-th free link, also counted from the lowest index.
- R4: An input that finds no free link in its direction sees ready low and keeps its packet. Every accepted packet comes out exactly once, on a link of the correct direction.
- R5: No link takes packets from two inputs in the same cycle. No more than `MULT` packets enter each direction per cycle.
- R6: While an output's valid is high and its ready is low, its valid stays high and its packet does not change on the next cycle.
- R7: A packet accepted on a clock edge is on its assigned link, with valid high, right after that edge.
- R8: After reset, every output valid is low.
- R9: An input whose valid is low never sees ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2*MULT | Valid for each incoming link |
| in_ready | output | 2*MULT | Ready for each incoming link |
| in_pkt | input | 2*MULT*PKT_W | Packed packets, address in the top bits; link i is in slice i |
| up_valid | output | MULT | Valid for each upper link |
| up_ready | input | MULT | Downstream ready for each upper link |
| up_pkt | output | MULT*PKT_W | Packets on the upper links |
| dn_valid | output | MULT | Valid for each lower link |
| dn_ready | input | MULT | Downstream ready for each lower link |
| dn_pkt | output | MULT*PKT_W | Packets on the lower links |

## Verification
The bench sends four packets bound for the same direction while two links are empty. An allocator that breaks the priority rule would grant the wrong pair of inputs, and one that double-books a link would make a packet vanish from the scoreboard. The bench also holds outputs stalled at random, so some links stay full while others drain in the same cycle. A design that treated a draining link as busy would hold ready low when it should be high. A design that overwrote a stalled register would lose packets or change data on a held output. A final drain phase catches any packet that was dropped or sent out twice.

// File: rtl/spl_pkg.sv
package spl_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} spl_dir_e;

  function automatic int unsigned route_bit_pos(int unsigned data_w,
                                                int unsigned addr_w,
                                                int unsigned level);
    return data_w + addr_w - 1 - level;
  endfunction
endpackage

// File: rtl/spl_dir_decode.sv
module spl_dir_decode
  import spl_pkg::*;
#(
  parameter int NIN    = 4,
  parameter int PKT_W  = 11,
  parameter int BITPOS = 9
) (
  input  logic [NIN-1:0]       in_valid,
  input  logic [NIN*PKT_W-1:0] in_pkt,
  output logic [NIN-1:0]       req_up,
  output logic [NIN-1:0]       req_dn
);
  for (genvar i = 0; i < NIN; i++) begin : g_dec
    spl_dir_e dir;
    assign dir       = spl_dir_e'(in_pkt[i*PKT_W + BITPOS]);
    assign req_up[i] = in_valid[i] && (dir == DIR_UP);
    assign req_dn[i] = in_valid[i] && (dir == DIR_DN);
  end
endmodule

// File: rtl/spl_link_alloc.sv
module spl_link_alloc #(
  parameter int NIN = 4,
  parameter int NL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIN-1:0]    req,
  input  logic [NL-1:0]     link_free,
  output logic [NIN-1:0]    grant,
  output logic [NL*NIN-1:0] src_oh
);
  localparam int CW = $clog2(NL + 1) + 1;

  always_comb begin
    int fcnt;
    int rank;
    int flist [NL];
    grant  = '0;
    src_oh = '0;
    fcnt   = 0;
    rank   = 0;
    for (int j = 0; j < NL; j++) flist[j] = 0;
    for (int j = 0; j < NL; j++) begin
      if (link_free[j]) begin
        flist[fcnt] = j;
        fcnt = fcnt + 1;
      end
    end
    for (int i = 0; i < NIN; i++) begin
      if (req[i]) begin
        if (rank < fcnt) begin
          grant[i] = 1'b1;
          src_oh[flist[rank]*NIN + i] = 1'b1;
        end
        rank = rank + 1;
      end
    end
  end

  for (genvar j = 0; j < NL; j++) begin : g_chk_link
    assert_one_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_oh[j*NIN +: NIN]));
    assert_busy_link_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !link_free[j] |-> (src_oh[j*NIN +: NIN] == '0));
  end

  for (genvar i = 0; i < NIN; i++) begin : g_chk_in
    assert_grant_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> req[i]);
  end

  assert_direction_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    CW'($countones(grant)) <= CW'(NL));
endmodule

// File: rtl/spl_out_stage.sv
module spl_out_stage #(
  parameter int PKT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PKT_W-1:0] load_pkt,
  output logic             free,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PKT_W-1:0] out_pkt
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pkt   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_pkt   <= load_pkt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));
  assert_load_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  assert_no_load_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
endmodule

// File: rtl/splitter_switch.sv
module splitter_switch
  import spl_pkg::*;
#(
  parameter int MULT   = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int LEVEL  = 1,
  localparam int NIN    = 2 * MULT,
  localparam int PKT_W  = ADDR_W + DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIN-1:0]       in_valid,
  output logic [NIN-1:0]       in_ready,
  input  logic [NIN*PKT_W-1:0] in_pkt,
  output logic [MULT-1:0]      up_valid,
  input  logic [MULT-1:0]      up_ready,
  output logic [MULT*PKT_W-1:0] up_pkt,
  output logic [MULT-1:0]      dn_valid,
  input  logic [MULT-1:0]      dn_ready,
  output logic [MULT*PKT_W-1:0] dn_pkt
);
  localparam int BITPOS = int'(route_bit_pos(DATA_W, ADDR_W, LEVEL));

  logic [NIN-1:0]       req_up, req_dn, gnt_up, gnt_dn;
  logic [MULT-1:0]      free_up, free_dn, load_up, load_dn;
  logic [MULT*NIN-1:0]  src_up, src_dn;
  logic [PKT_W-1:0]     mux_up [MULT];
  logic [PKT_W-1:0]     mux_dn [MULT];

  spl_dir_decode #(.NIN(NIN), .PKT_W(PKT_W), .BITPOS(BITPOS)) u_dec (
    .in_valid(in_valid), .in_pkt(in_pkt), .req_up(req_up), .req_dn(req_dn)
  );

  spl_link_alloc #(.NIN(NIN), .NL(MULT)) u_alloc_up (
    .clk(clk), .rst_n(rst_n), .req(req_up), .link_free(free_up),
    .grant(gnt_up), .src_oh(src_up)
  );

  spl_link_alloc #(.NIN(NIN), .NL(MULT)) u_alloc_dn (
    .clk(clk), .rst_n(rst_n), .req(req_dn), .link_free(free_dn),
    .grant(gnt_dn), .src_oh(src_dn)
  );

  assign in_ready = gnt_up | gnt_dn;

  for (genvar j = 0; j < MULT; j++) begin : g_link
    always_comb begin
      mux_up[j] = '0;
      mux_dn[j] = '0;
      for (int i = 0; i < NIN; i++) begin
        if (src_up[j*NIN + i]) mux_up[j] = mux_up[j] | in_pkt[i*PKT_W +: PKT_W];
        if (src_dn[j*NIN + i]) mux_dn[j] = mux_dn[j] | in_pkt[i*PKT_W +: PKT_W];
      end
    end
    assign load_up[j] = |src_up[j*NIN +: NIN];
    assign load_dn[j] = |src_dn[j*NIN +: NIN];

    spl_out_stage #(.PKT_W(PKT_W)) u_up (
      .clk(clk), .rst_n(rst_n), .load(load_up[j]), .load_pkt(mux_up[j]),
      .free(free_up[j]), .out_valid(up_valid[j]), .out_ready(up_ready[j]),
      .out_pkt(up_pkt[j*PKT_W +: PKT_W])
    );
    spl_out_stage #(.PKT_W(PKT_W)) u_dn (
      .clk(clk), .rst_n(rst_n), .load(load_dn[j]), .load_pkt(mux_dn[j]),
      .free(free_dn[j]), .out_valid(dn_valid[j]), .out_ready(dn_ready[j]),
      .out_pkt(dn_pkt[j*PKT_W +: PKT_W])
    );

    assert_up_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid[j] |-> !up_pkt[j*PKT_W + BITPOS]);
    assert_dn_bit_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid[j] |-> dn_pkt[j*PKT_W + BITPOS]);
  end

  for (genvar i = 0; i < NIN; i++) begin : g_in_chk
    assert_single_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_up[i] && gnt_dn[i]));
    assert_idle_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[i] |-> !in_ready[i]);
  end

  assert_reset_clears_R8: assert property (@(posedge clk)
    !rst_n |=> (up_valid == '0 && dn_valid == '0));
endmodule

// File: tb/splitter_switch_tb_top.sv
module splitter_switch_tb_top;
  localparam int MULT   = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int LEVEL  = 1;
  localparam int NIN    = 2 * MULT;
  localparam int PKT_W  = ADDR_W + DATA_W;
  localparam int BITPOS = DATA_W + ADDR_W - 1 - LEVEL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIN-1:0]        in_valid = '0;
  logic [NIN-1:0]        in_ready;
  logic [NIN*PKT_W-1:0]  in_pkt = '0;
  logic [MULT-1:0]       up_valid, dn_valid;
  logic [MULT-1:0]       up_ready = '0, dn_ready = '0;
  logic [MULT*PKT_W-1:0] up_pkt, dn_pkt;

  always #5 clk = ~clk;

  splitter_switch #(.MULT(MULT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEVEL(LEVEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .up_valid(up_valid), .up_ready(up_ready), .up_pkt(up_pkt),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_pkt(dn_pkt)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seq = 0;

  logic             pend_v   [NIN];
  logic [PKT_W-1:0] pend_pkt [NIN];
  logic [PKT_W-1:0] qu [MULT][$];
  logic [PKT_W-1:0] qd [MULT][$];
  int               ld_cyc_u [MULT];
  int               ld_cyc_d [MULT];
  logic [PKT_W-1:0] ld_pkt_u [MULT];
  logic [PKT_W-1:0] ld_pkt_d [MULT];
  logic             stall_u  [MULT];
  logic             stall_d  [MULT];
  logic [PKT_W-1:0] prev_u   [MULT];
  logic [PKT_W-1:0] prev_d   [MULT];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: drives inputs, predicts ready and pushes expected packets per link.
  task automatic step(input int gen_pct, input int rdy_pct);
    int fu, fd, ru, rd;
    int lu [MULT];
    int ldn [MULT];
    @(negedge clk);
    for (int i = 0; i < NIN; i++) begin
      if (!pend_v[i] && ($urandom % 100) < gen_pct) begin
        pend_v[i]   = 1'b1;
        pend_pkt[i] = {3'($urandom), 8'(seq)};
        seq++;
      end
      in_valid[i] = pend_v[i];
      in_pkt[i*PKT_W +: PKT_W] = pend_pkt[i];
    end
    for (int j = 0; j < MULT; j++) begin
      up_ready[j] = ($urandom % 100) < rdy_pct;
      dn_ready[j] = ($urandom % 100) < rdy_pct;
    end
    #2;
    fu = 0; fd = 0; ru = 0; rd = 0;
    for (int j = 0; j < MULT; j++) begin
      lu[j] = 0; ldn[j] = 0;
    end
    for (int j = 0; j < MULT; j++) begin
      if (!up_valid[j] || up_ready[j]) begin lu[fu] = j; fu++; end
      if (!dn_valid[j] || dn_ready[j]) begin ldn[fd] = j; fd++; end
    end
    for (int i = 0; i < NIN; i++) begin
      logic exp_r;
      exp_r = 1'b0;
      if (pend_v[i]) begin
        if (!pend_pkt[i][BITPOS]) begin
          if (ru < fu) begin
            exp_r = 1'b1;
            qu[lu[ru]].push_back(pend_pkt[i]);
            ld_cyc_u[lu[ru]] = cyc;
            ld_pkt_u[lu[ru]] = pend_pkt[i];
          end
          ru++;
        end else begin
          if (rd < fd) begin
            exp_r = 1'b1;
            qd[ldn[rd]].push_back(pend_pkt[i]);
            ld_cyc_d[ldn[rd]] = cyc;
            ld_pkt_d[ldn[rd]] = pend_pkt[i];
          end
          rd++;
        end
      end
      // R2 R3 R4 R9: ready follows priority order over free links
      check(in_ready[i] == exp_r, "R3/R4 in_ready", 32'(in_ready[i]), 32'(exp_r));
      if (in_ready[i]) pend_v[i] = 1'b0;
    end
  endtask

  // Monitor: pops expected packets as links hand them off.
  initial begin
    for (int j = 0; j < MULT; j++) begin
      stall_u[j] = 1'b0; stall_d[j] = 1'b0;
    end
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        for (int j = 0; j < MULT; j++) begin
          if (ld_cyc_u[j] == cyc - 1) begin
            check(up_valid[j] && up_pkt[j*PKT_W +: PKT_W] == ld_pkt_u[j], "R7 up load",
                  32'(up_pkt[j*PKT_W +: PKT_W]), 32'(ld_pkt_u[j]));
          end
          if (ld_cyc_d[j] == cyc - 1) begin
            check(dn_valid[j] && dn_pkt[j*PKT_W +: PKT_W] == ld_pkt_d[j], "R7 dn load",
                  32'(dn_pkt[j*PKT_W +: PKT_W]), 32'(ld_pkt_d[j]));
          end
          if (stall_u[j])
            check(up_valid[j] && up_pkt[j*PKT_W +: PKT_W] == prev_u[j], "R6 up hold",
                  32'(up_pkt[j*PKT_W +: PKT_W]), 32'(prev_u[j]));
          if (stall_d[j])
            check(dn_valid[j] && dn_pkt[j*PKT_W +: PKT_W] == prev_d[j], "R6 dn hold",
                  32'(dn_pkt[j*PKT_W +: PKT_W]), 32'(prev_d[j]));
          stall_u[j] = up_valid[j] && !up_ready[j];
          stall_d[j] = dn_valid[j] && !dn_ready[j];
          prev_u[j]  = up_pkt[j*PKT_W +: PKT_W];
          prev_d[j]  = dn_pkt[j*PKT_W +: PKT_W];
          if (up_valid[j] && up_ready[j]) begin
            if (qu[j].size() == 0) check(1'b0, "R4 up extra packet", 32'(up_pkt[j*PKT_W +: PKT_W]), 32'h0);
            else begin
              logic [PKT_W-1:0] e;
              e = qu[j].pop_front();
              check(up_pkt[j*PKT_W +: PKT_W] == e, "R1/R4 up data", 32'(up_pkt[j*PKT_W +: PKT_W]), 32'(e));
            end
          end
          if (dn_valid[j] && dn_ready[j]) begin
            if (qd[j].size() == 0) check(1'b0, "R4 dn extra packet", 32'(dn_pkt[j*PKT_W +: PKT_W]), 32'h0);
            else begin
              logic [PKT_W-1:0] e;
              e = qd[j].pop_front();
              check(dn_pkt[j*PKT_W +: PKT_W] == e, "R1/R4 dn data", 32'(dn_pkt[j*PKT_W +: PKT_W]), 32'(e));
            end
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int left;
    for (int i = 0; i < NIN; i++) begin pend_v[i] = 1'b0; pend_pkt[i] = '0; end
    for (int j = 0; j < MULT; j++) begin
      ld_cyc_u[j] = -5; ld_cyc_d[j] = -5; ld_pkt_u[j] = '0; ld_pkt_d[j] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R8: reset leaves every link empty; R9: idle inputs are not ready
    check(up_valid == '0, "R8 up_valid", 32'(up_valid), 32'h0);
    check(dn_valid == '0, "R8 dn_valid", 32'(dn_valid), 32'h0);
    check(in_ready == '0, "R9 idle ready", 32'(in_ready), 32'h0);

    // R3: four upward packets, two empty up links -> inputs 0 and 1 win
    pend_v[0] = 1'b1; pend_pkt[0] = {3'b000, 8'hA0};
    pend_v[1] = 1'b1; pend_pkt[1] = {3'b001, 8'hA1};
    pend_v[2] = 1'b1; pend_pkt[2] = {3'b100, 8'hA2};
    pend_v[3] = 1'b1; pend_pkt[3] = {3'b101, 8'hA3};
    step(0, 0);
    check(in_ready == 4'b0011, "R3 priority", 32'(in_ready), 32'h3);
    step(0, 0);
    // R5: both up links full and stalled -> nobody placed
    check(in_ready == 4'b0000, "R5 full links", 32'(in_ready), 32'h0);
    step(0, 100);
    check(in_ready == 4'b1100, "R2 draining links free", 32'(in_ready), 32'hC);
    repeat (4) step(0, 100);

    repeat (1500) step(70, 35);
    repeat (1000) step(100, 100);
    repeat (500) step(50, 80);

    // Drain; R4: nothing lost or duplicated
    repeat (40) step(0, 100);
    left = 0;
    for (int j = 0; j < MULT; j++) left += qu[j].size() + qd[j].size();
    for (int i = 0; i < NIN; i++) left += int'(pend_v[i]);
    check(left == 0, "R4 drained", 32'(left), 32'h0);
    check(up_valid == '0 && dn_valid == '0, "R4 links empty", 32'({up_valid, dn_valid}), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule